// File: doc/BRIEF.md
# E1 Alarm Persistence Timer

This block sits beside an E1 receive framer and keeps the timing of line conditions. It counts 125 µs frame strobes to build a millisecond tick. From that tick it derives half-second and one-second heartbeat bits. It also runs a one-shot multiframe-alignment window timer and keeps a millisecond heartbeat that re-phases to the received CRC-4 multiframe pulse once alignment has been reached.

Three persistence timers qualify the framer's condition inputs:
- Keep-alive reports AIS that has stayed high without a break.
- T1 reports a loss of terminal frame sync that has lasted long enough.
- T2 reports terminal frame sync that has held long enough.

These timers set and clear on different events. T1 stays set after sync comes back and is cleared only when T2 rises. T2 is knocked down by a single non-normal frame.

All results are presented together as one 8-bit status byte, which the host reads through its own bus decode.

Top module: `e1_alarm_timer`

## Requirements
- R1: A synchronous active-high reset clears every counter, toggle and flag, so `status_o` reads 8'h00 after reset.
- R2: A millisecond tick occurs on every FRAMES_PER_MS-th frame strobe. Bit 7 inverts each time HALF_SEC_MS further ticks have elapsed, so it equals floor(ticks/HALF_SEC_MS) mod 2.
- R3: Bit 6 equals floor(ticks/(2·HALF_SEC_MS)) mod 2. It changes only on a clock in which bit 7 also changes.
- R4: A start strobe (re)starts the window timer from zero. WIN_MS ticks after the latest start, bit 5 inverts once and the timer stops. Later ticks do nothing until the next start strobe. A start in the same clock as a tick wins over that tick.
- R5: Bit 4 always reads 0.
- R6: While the multiframe-aligned input is low, bit 3 inverts on every FRAMES_PER_MS-th frame strobe counted by its own phase counter.
- R7: While the multiframe-aligned input is high, a multiframe sync pulse inverts bit 3 at once and restarts its phase counter from zero. A frame strobe in the same clock is absorbed.
- R8: Bit 2 (keep-alive) rises once AIS has been high without a break for KA_MS ticks.
- R9: Bit 2 is low from the first clock after AIS is sampled low.
- R10: Bit 1 (T1) sets when sync-loss has lasted LOS_MS ticks. It stays set even if sync returns, and clears only on the clock in which bit 0 rises.
- R11: Bit 0 (T2) is high once sync has been present, with no non-normal frame flagged, for SYNC_MS ticks. It is low from the first clock after a non-normal frame or a loss of sync.
- R12: Any break in a qualifying condition restarts its persistence count from zero. Only uninterrupted durations set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| frame_stb_i | input | 1 | One-clock pulse per 125 µs frame |
| ais_i | input | 1 | AIS detected |
| sync_ok_i | input | 1 | Terminal frame sync present |
| bad_frame_i | input | 1 | Non-normal operational frame received (pulse) |
| mf_sync_i | input | 1 | Received CRC-4 multiframe sync pulse |
| mf_aligned_i | input | 1 | CRC-4 multiframe alignment achieved |
| win_start_i | input | 1 | Starts the alignment window timer |
| status_o | output | 8 | Timer status byte |

## Verification
The bound checker watches the following on every cycle:
- bit 4 stays zero;
- bit 6 never moves without bit 7;
- the heartbeat bits move only after a millisecond tick, or after a frame strobe or multiframe pulse in the case of bit 3;
- keep-alive and T2 drop one clock after their condition is removed;
- T1 and T2 never rise together with the other one set.

Whether a flag rises after exactly the right number of uninterrupted milliseconds, whether a short interruption really restarts a count, and the exact expiry and restart point of the window timer can only be shown by the bench's scenarios. The bench compares the whole status byte every cycle against an arithmetic model, across several strobe spacings.

// File: rtl/e1at_pkg.sv
package e1at_pkg;

  // Field layout of the status byte (bit 7 first).
  typedef struct packed {
    logic half_sec;
    logic one_sec;
    logic win_tog;
    logic spare;
    logic mf_ms;
    logic keep_alive;
    logic t1_loss;
    logic t2_sync;
  } e1at_status_t;

  // Bits needed to hold a count from 0 up to and including top.
  function automatic int unsigned cnt_bits(int unsigned top);
    return (top < 1) ? 1 : $clog2(top + 1);
  endfunction

  // Half-second edge: last tick of either half of the one-second period.
  function automatic logic half_edge(int unsigned cnt, int unsigned half);
    return (cnt == half - 1) || (cnt == 2 * half - 1);
  endfunction

endpackage

// File: rtl/e1at_timebase.sv
module e1at_timebase #(
  parameter int unsigned FRAMES_PER_MS = 8,
  parameter int unsigned HALF_SEC_MS   = 500
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fs_i,
  output logic ms_tick_o,
  output logic half_tog_o,
  output logic sec_tog_o
);
  localparam int unsigned FW = e1at_pkg::cnt_bits(FRAMES_PER_MS - 1);
  localparam int unsigned MW = e1at_pkg::cnt_bits(2 * HALF_SEC_MS - 1);
  localparam logic [FW-1:0] F_LAST = FW'(FRAMES_PER_MS - 1);
  localparam logic [MW-1:0] M_LAST = MW'(2 * HALF_SEC_MS - 1);

  logic [FW-1:0] frame_q;
  logic [MW-1:0] ms_q;
  logic          half_edge;
  logic          sec_edge;

  assign ms_tick_o = fs_i && (frame_q == F_LAST);
  assign half_edge = ms_tick_o && e1at_pkg::half_edge(32'(ms_q), HALF_SEC_MS);
  assign sec_edge  = ms_tick_o && (ms_q == M_LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      frame_q <= '0;
    end else if (fs_i) begin
      frame_q <= (frame_q == F_LAST) ? '0 : frame_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ms_q       <= '0;
      half_tog_o <= 1'b0;
      sec_tog_o  <= 1'b0;
    end else if (ms_tick_o) begin
      ms_q <= (ms_q == M_LAST) ? '0 : ms_q + 1'b1;
      if (half_edge) half_tog_o <= ~half_tog_o;
      if (sec_edge)  sec_tog_o  <= ~sec_tog_o;
    end
  end
endmodule

// File: rtl/e1at_mfclock.sv
module e1at_mfclock #(
  parameter int unsigned FRAMES_PER_MS = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fs_i,
  input  logic aligned_i,
  input  logic mf_sync_i,
  output logic tog_o
);
  localparam int unsigned PW = e1at_pkg::cnt_bits(FRAMES_PER_MS - 1);
  localparam logic [PW-1:0] P_LAST = PW'(FRAMES_PER_MS - 1);

  logic [PW-1:0] phase_q;
  logic          rephase;

  assign rephase = aligned_i && mf_sync_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= '0;
      tog_o   <= 1'b0;
    end else if (rephase) begin
      phase_q <= '0;
      tog_o   <= ~tog_o;
    end else if (fs_i) begin
      if (phase_q == P_LAST) begin
        phase_q <= '0;
        tog_o   <= ~tog_o;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/e1at_persist.sv
module e1at_persist #(
  parameter int unsigned LIMIT_MS = 100
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ms_tick_i,
  input  logic cond_i,
  output logic full_o,
  output logic hit_o
);
  localparam int unsigned CW = e1at_pkg::cnt_bits(LIMIT_MS);
  localparam logic [CW-1:0] LIM    = CW'(LIMIT_MS);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT_MS - 1);

  logic [CW-1:0] cnt_q;

  assign full_o = (cnt_q == LIM);
  assign hit_o  = ms_tick_i && cond_i && (cnt_q == LIM_M1);

  always_ff @(posedge clk_i) begin
    if (rst_i || !cond_i) begin
      cnt_q <= '0;
    end else if (ms_tick_i && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/e1at_window.sv
module e1at_window #(
  parameter int unsigned WIN_MS = 400
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ms_tick_i,
  input  logic start_i,
  output logic tog_o
);
  localparam int unsigned WW = e1at_pkg::cnt_bits(WIN_MS - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WIN_MS - 1);

  logic [WW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      tog_o <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (ms_tick_i && run_q) begin
      if (cnt_q == W_LAST) begin
        cnt_q <= '0;
        run_q <= 1'b0;
        tog_o <= ~tog_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/e1_alarm_timer.sv
module e1_alarm_timer #(
  parameter int unsigned FRAMES_PER_MS = 8,
  parameter int unsigned HALF_SEC_MS   = 500,
  parameter int unsigned KA_MS         = 100,
  parameter int unsigned LOS_MS        = 100,
  parameter int unsigned SYNC_MS       = 10,
  parameter int unsigned WIN_MS        = 400
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       frame_stb_i,
  input  logic       ais_i,
  input  logic       sync_ok_i,
  input  logic       bad_frame_i,
  input  logic       mf_sync_i,
  input  logic       mf_aligned_i,
  input  logic       win_start_i,
  output logic [7:0] status_o
);
  import e1at_pkg::*;

  // Named internal events, visible to the bound checker.
  logic ms_tick;
  logic half_tog, sec_tog, win_tog, mf_tog;
  logic ka_full, ka_hit;
  logic los_full, los_hit;
  logic sy_full, sy_hit;
  logic sy_cond;
  logic t1_q;
  e1at_status_t st;

  e1at_timebase #(.FRAMES_PER_MS(FRAMES_PER_MS), .HALF_SEC_MS(HALF_SEC_MS)) u_tb (
    .clk_i(clk_i), .rst_i(rst_i), .fs_i(frame_stb_i),
    .ms_tick_o(ms_tick), .half_tog_o(half_tog), .sec_tog_o(sec_tog)
  );

  e1at_mfclock #(.FRAMES_PER_MS(FRAMES_PER_MS)) u_mf (
    .clk_i(clk_i), .rst_i(rst_i), .fs_i(frame_stb_i),
    .aligned_i(mf_aligned_i), .mf_sync_i(mf_sync_i), .tog_o(mf_tog)
  );

  e1at_window #(.WIN_MS(WIN_MS)) u_win (
    .clk_i(clk_i), .rst_i(rst_i), .ms_tick_i(ms_tick),
    .start_i(win_start_i), .tog_o(win_tog)
  );

  e1at_persist #(.LIMIT_MS(KA_MS)) u_ka (
    .clk_i(clk_i), .rst_i(rst_i), .ms_tick_i(ms_tick), .cond_i(ais_i),
    .full_o(ka_full), .hit_o(ka_hit)
  );

  e1at_persist #(.LIMIT_MS(LOS_MS)) u_los (
    .clk_i(clk_i), .rst_i(rst_i), .ms_tick_i(ms_tick), .cond_i(!sync_ok_i),
    .full_o(los_full), .hit_o(los_hit)
  );

  // A non-normal frame breaks the sync qualification as well as clearing T2.
  assign sy_cond = sync_ok_i && !bad_frame_i;

  e1at_persist #(.LIMIT_MS(SYNC_MS)) u_sy (
    .clk_i(clk_i), .rst_i(rst_i), .ms_tick_i(ms_tick), .cond_i(sy_cond),
    .full_o(sy_full), .hit_o(sy_hit)
  );

  // T1: set on reaching the loss limit, cleared only when T2 rises.
  always_ff @(posedge clk_i) begin
    if (rst_i || sy_hit) begin
      t1_q <= 1'b0;
    end else if (los_hit) begin
      t1_q <= 1'b1;
    end
  end

  assign st.half_sec   = half_tog;
  assign st.one_sec    = sec_tog;
  assign st.win_tog    = win_tog;
  assign st.spare      = 1'b0;
  assign st.mf_ms      = mf_tog;
  assign st.keep_alive = ka_full;
  assign st.t1_loss    = t1_q;
  assign st.t2_sync    = sy_full;
  assign status_o      = st;

  logic unused_ok;
  assign unused_ok = ka_hit ^ los_full;
endmodule

// File: rtl/e1at_chk.sv
module e1at_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       fs_i,
  input logic       ais_i,
  input logic       bad_frame_i,
  input logic       mf_sync_i,
  input logic       mf_aligned_i,
  input logic       ms_tick_i,
  input logic [7:0] status_i
);
  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (status_i == 8'h00));

  // R2
  half_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_i[7] != $past(status_i[7])) |-> $past(ms_tick_i));

  // R3
  sec_aligned_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_i[6] != $past(status_i[6])) |-> (status_i[7] != $past(status_i[7])));

  // R4
  win_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_i[5] != $past(status_i[5])) |-> $past(ms_tick_i));

  // R5
  spare_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    status_i[4] == 1'b0);

  // R6
  mf_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_i[3] != $past(status_i[3])) |-> ($past(fs_i) || $past(mf_sync_i && mf_aligned_i)));

  // R8
  ka_needs_ais_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(status_i[2]) |-> $past(ais_i));

  // R9
  ka_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !ais_i |=> !status_i[2]);

  // R10
  t1_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(status_i[1]) |-> !status_i[0]);

  // R10
  t1_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(status_i[0]) |-> !status_i[1]);

  // R11
  t2_bad_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    bad_frame_i |=> !status_i[0]);
endmodule

bind e1_alarm_timer e1at_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .fs_i(frame_stb_i), .ais_i(ais_i),
  .bad_frame_i(bad_frame_i), .mf_sync_i(mf_sync_i), .mf_aligned_i(mf_aligned_i),
  .ms_tick_i(ms_tick), .status_i(status_o)
);

// File: tb/e1_alarm_timer_bench.sv
module e1_alarm_timer_bench;
  localparam int F = 2, H = 3, KA = 4, LOS = 4, SY = 3, WIN = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, fs = 1'b0, ais = 1'b0, sync = 1'b0, bad = 1'b0;
  logic mfs = 1'b0, mfa = 1'b0, start = 1'b0;
  logic [7:0] status;

  e1_alarm_timer #(.FRAMES_PER_MS(F), .HALF_SEC_MS(H), .KA_MS(KA), .LOS_MS(LOS),
                   .SYNC_MS(SY), .WIN_MS(WIN)) u_e1_alarm_timer (
    .clk_i(clk), .rst_i(rst), .frame_stb_i(fs), .ais_i(ais), .sync_ok_i(sync),
    .bad_frame_i(bad), .mf_sync_i(mfs), .mf_aligned_i(mfa), .win_start_i(start),
    .status_o(status)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  // Arithmetic model state
  int fcnt, ms_total, cc, ais_run, los_run, sy_run, wc;
  bit b3, ka, t1, t2, los_full, wrun, b5;

  function automatic logic [7:0] expected();
    return {1'((ms_total / H) % 2), 1'((ms_total / (2 * H)) % 2), b5, 1'b0, b3, ka, t1, t2};
  endfunction

  always @(posedge clk) begin
    int tick;
    bit nt2, nlos;
    if (rst) begin
      fcnt = 0; ms_total = 0; cc = 0; ais_run = 0; los_run = 0; sy_run = 0; wc = 0;
      b3 = 0; ka = 0; t1 = 0; t2 = 0; los_full = 0; wrun = 0; b5 = 0;
    end else begin
      tick = 0;
      if (fs) begin
        fcnt++;
        if (fcnt == F) begin fcnt = 0; tick = 1; ms_total++; end
      end
      if (mfa && mfs) begin b3 = !b3; cc = 0; end
      else if (fs) begin cc++; if (cc == F) begin cc = 0; b3 = !b3; end end
      ais_run = ais ? ais_run + tick : 0;
      los_run = !sync ? los_run + tick : 0;
      sy_run  = (sync && !bad) ? sy_run + tick : 0;
      nt2  = (sy_run >= SY);
      nlos = (los_run >= LOS);
      if (nt2 && !t2) t1 = 0;
      else if (nlos && !los_full) t1 = 1;
      t2 = nt2; los_full = nlos; ka = (ais_run >= KA);
      if (start) begin wrun = 1; wc = 0; end
      else if (tick == 1 && wrun) begin
        wc++;
        if (wc == WIN) begin wc = 0; wrun = 0; b5 = !b5; end
      end
    end
  end

  function automatic string tag_of(int b);
    case (b)
      7: return "R2";
      6: return "R3";
      5: return "R4";
      4: return "R5";
      3: return mfa ? "R7" : "R6";
      2: return ais ? "R8" : "R9";
      1: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Whole-byte compare every cycle
  always @(negedge clk) begin
    logic [7:0] e;
    if (!rst && !done) begin
      e = expected();
      n_vec++;
      if (status !== e) begin
        n_bad++;
        for (int b = 7; b >= 0; b--) begin
          if (status[b] !== e[b]) begin
            $display("FAIL %s bit%0d cyc %0d got %b expected %b", tag_of(b), b, cyc, status, e);
            break;
          end
        end
      end
    end
  end

  task automatic named(string tag, logic got, logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(int nclk, int period);
    for (int k = 0; k < nclk; k++) begin
      @(negedge clk);
      fs = (period != 0) && (k % period == 0);
    end
    @(negedge clk);
    fs = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      n_bad++;
      $display("FAIL R1 watchdog got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (status !== 8'h00) begin n_bad++; $display("FAIL R1 got %h expected 00", status); end
    rst = 1'b0;

    // Free run with sync absent across several strobe spacings (R2, R3, R6, R10)
    for (int p = 1; p <= 4; p++) drive(120, p);
    named("R10 loss sets T1", status[1], 1'b1);

    // Sync returns: T2 qualifies and clears T1 (R10, R11)
    @(negedge clk); sync = 1'b1;
    drive(20, 2);
    named("R11 T2 set", status[0], 1'b1);
    named("R10 T1 cleared by T2", status[1], 1'b0);

    // Non-normal frame knocks T2 down next clock (R11)
    @(negedge clk); bad = 1'b1;
    @(negedge clk); bad = 1'b0;
    named("R11 T2 cleared by bad frame", status[0], 1'b0);
    drive(20, 1);
    named("R11 T2 requalified", status[0], 1'b1);

    // Short sync losses must not set T1 (R12)
    for (int g = 0; g < 5; g++) begin
      @(negedge clk); sync = 1'b0;
      drive(5, 1);
      @(negedge clk); sync = 1'b1;
      drive(2, 1);
    end
    named("R12 T1 not set by short losses", status[1], 1'b0);

    // Short AIS bursts then sustained AIS (R12, R8, R9)
    for (int g = 0; g < 4; g++) begin
      @(negedge clk); ais = 1'b1;
      drive(5, 1);
      @(negedge clk); ais = 1'b0;
      drive(2, 1);
    end
    named("R12 keep-alive not set by bursts", status[2], 1'b0);
    @(negedge clk); ais = 1'b1;
    drive(20, 1);
    named("R8 keep-alive set", status[2], 1'b1);
    @(negedge clk); ais = 1'b0;
    @(negedge clk);
    named("R9 keep-alive dropped", status[2], 1'b0);

    // Multiframe alignment re-phasing of bit 3 (R7)
    @(negedge clk); mfa = 1'b1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      fs  = (k % 2 == 0);
      mfs = (k % 5 == 3) || (k % 7 == 0);
    end
    @(negedge clk); fs = 1'b0; mfs = 1'b0; mfa = 1'b0;

    // Window timer: single expiry, restart, start colliding with tick (R4)
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    drive(30, 1);
    named("R4 window expired once", status[5], 1'b1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    drive(6, 1);
    @(negedge clk); start = 1'b1; fs = 1'b1;
    @(negedge clk); start = 1'b0; fs = 1'b0;
    drive(40, 3);
    named("R4 window expired after restart", status[5], 1'b0);
    named("R5 spare bit", status[4], 1'b0);

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule